// File: doc/BRIEF.md
# DRAM initialization command sequencer

This block lets firmware bring up a DDR memory by hand during power-on. It sits behind one 32-bit control word. Firmware uses that word to release memory reset, to raise clock enable and to enter a software-driven initialization mode. It then requests single commands: precharge-all, auto-refresh and mode-register load. It polls the request bits to learn when each command is done.

The sequencer puts each request on the chip-select, row-strobe, column-strobe and write-enable pins, together with the address and bank pins. Only one command is active at a time. After the chip-select cycle it counts a per-command settling time, set by a parameter. On the cycle that count runs out, it clears the request bit itself. An optional two-cycle timing mode holds address, bank and the three strobes for an extra setup cycle. In that mode chip select goes low only in the second cycle. A status output rises when firmware leaves initialization mode.

Top module: `dram_init_seq`

## Requirements
- R1: Control-word bits [15:0] and [18:16] are stored on every write and read back in place. A mode-register command drives them unchanged onto the address and bank pins.
- R2: Pin encodings as {csN,rasN,casN,weN}. Precharge-all is 0,0,1,0 with address 16'h0400 and bank 0. Auto-refresh is 0,0,0,1 with address and bank 0. Mode-register load is 0,0,0,0. When no command is driven the pins show 1,1,1,1 with address and bank 0.
- R3: Writing 1 to bit 24 requests precharge-all, bit 25 requests auto-refresh and bit 26 requests mode-register load. A request bit stays set until the hardware clears it, T cycles after its chip-select cycle. T is T_RP, T_RFC or T_MRD for these three commands. Writing 0 never cancels a pending request.
- R4: A request is accepted only if, before the write, init mode (bit 31) is set and clock enable is already high. Otherwise the request bit stays 0 and no command is driven.
- R5: When several requests are pending, the next one served is precharge-all first, then auto-refresh, then mode-register load. A new command starts no earlier than the cycle after the previous request clears.
- R6: Writing 1 to bit 27 drives memResetN high. No later write brings it low; only block reset does. Bit 27 reads back the released state.
- R7: Writing 1 to bit 28 drives memCke high. No later write brings it low. Bit 28 reads back that state.
- R8: dramEnabled rises on a write that changes bit 31 from 1 to 0. It stays high until block reset.
- R9: With twoTMode high when a command starts, the command's address, bank and strobes are driven for two cycles. Chip select is high in the first of those cycles and low in the second. The settling count starts from the chip-select cycle.
- R10: Bits [23:19] and [30:29] always read 0, whatever is written to them.
- R11: While rstN is low at a clock edge, the block returns to: memResetN low, memCke low, NOP pins, all control bits 0, dramEnabled low.
- R12: In one-cycle mode, a request written at clock edge k drives its command at edge k+1. Chip select is low for exactly one cycle per command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory-side clock |
| rstN | input | 1 | Synchronous active-low reset |
| regWrEn | input | 1 | Write strobe for the control word |
| regWrData | input | 32 | Write data for the control word |
| regRdData | output | 32 | Current control word |
| twoTMode | input | 1 | Selects two-cycle address/command timing |
| memResetN | output | 1 | Memory reset, active low |
| memCke | output | 1 | Memory clock enable |
| memCsN | output | 1 | Chip select, active low |
| memRasN | output | 1 | Row strobe, active low |
| memCasN | output | 1 | Column strobe, active low |
| memWeN | output | 1 | Write enable, active low |
| memAddr | output | 16 | Memory address pins |
| memBank | output | 3 | Memory bank pins |
| dramEnabled | output | 1 | Initialization complete flag |

## Verification
Faults in the internal state show up at the pins or in the readback within a few cycles. A wrong command choice shows as a wrong strobe pattern on the very cycle chip select falls. A wrong settling count shows as a request bit that clears one cycle early or late. A lost one-way flag shows the cycle after the offending write. The bench's reference model predicts every pin and readback bit on every cycle, so each such fault is flagged on the first cycle it is visible.

// File: rtl/dram_init_pkg.sv
package dram_init_pkg;

  // Request bit positions in the control word; bit order sets service priority.
  localparam int REQ_LSB   = 24;
  localparam int REL_BIT   = 27;
  localparam int CKE_BIT   = 28;
  localparam int INIT_BIT  = 31;
  localparam int ADDR_W    = 16;
  localparam int BANK_W    = 3;
  localparam int NUM_REQ   = 3;

  typedef enum logic [1:0] {
    CMD_PREA = 2'd0,
    CMD_REF  = 2'd1,
    CMD_MRS  = 2'd2
  } cmd_e;

  typedef struct packed {
    logic loadCmd;   // latch command fields onto pins
    logic csAssert;  // drive chip select low this cycle
    logic loadCnt;   // start settling count
    logic clrReq;    // retire current request
    cmd_e cmd;
  } ctl_strobe_t;

endpackage

// File: rtl/dram_init_timer.sv
module dram_init_timer
  import dram_init_pkg::*;
#(
  parameter int T_RP  = 3,
  parameter int T_RFC = 8,
  parameter int T_MRD = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic loadCnt,
  input  cmd_e cmd,
  output logic cntLast
);

  localparam int T_MAX = (T_RP > T_RFC) ? ((T_RP > T_MRD) ? T_RP : T_MRD)
                                        : ((T_RFC > T_MRD) ? T_RFC : T_MRD);
  localparam int CNT_W = $clog2(T_MAX + 1);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] loadVal;

  always_comb begin
    unique case (cmd)
      CMD_PREA: loadVal = CNT_W'(T_RP);
      CMD_REF:  loadVal = CNT_W'(T_RFC);
      default:  loadVal = CNT_W'(T_MRD);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN)              cnt <= '0;
    else if (loadCnt)       cnt <= loadVal;
    else if (cnt != '0)     cnt <= cnt - 1'b1;
  end

  assign cntLast = (cnt == CNT_W'(1));

endmodule

// File: rtl/dram_init_ctl.sv
module dram_init_ctl
  import dram_init_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_REQ-1:0] reqPend,
  input  logic               twoTMode,
  input  logic               cntLast,
  output ctl_strobe_t        strobe
);

  typedef enum logic [1:0] {ST_IDLE, ST_SETUP, ST_WAIT} state_e;

  state_e state, nextState;
  cmd_e   curCmd, nextCmd, pickCmd;

  always_comb begin
    if (reqPend[0])      pickCmd = CMD_PREA;
    else if (reqPend[1]) pickCmd = CMD_REF;
    else                 pickCmd = CMD_MRS;
  end

  always_comb begin
    strobe     = '0;
    strobe.cmd = curCmd;
    nextState  = state;
    nextCmd    = curCmd;
    unique case (state)
      ST_IDLE: begin
        if (reqPend != '0) begin
          strobe.cmd     = pickCmd;
          strobe.loadCmd = 1'b1;
          nextCmd        = pickCmd;
          if (twoTMode) begin
            nextState = ST_SETUP;
          end else begin
            strobe.csAssert = 1'b1;
            strobe.loadCnt  = 1'b1;
            nextState       = ST_WAIT;
          end
        end
      end
      ST_SETUP: begin
        strobe.csAssert = 1'b1;
        strobe.loadCnt  = 1'b1;
        nextState       = ST_WAIT;
      end
      default: begin
        if (cntLast) begin
          strobe.clrReq = 1'b1;
          nextState     = ST_IDLE;
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      curCmd <= CMD_PREA;
    end else begin
      state  <= nextState;
      curCmd <= nextCmd;
    end
  end

  // R5: a command starts only from idle, so a second cannot overlap the first
  assert_single_flight_R5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadCmd |=> (state != ST_IDLE));

endmodule

// File: rtl/dram_init_dp.sv
module dram_init_dp
  import dram_init_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWrEn,
  input  logic [31:0]        regWrData,
  input  ctl_strobe_t        strobe,
  output logic [31:0]        regRdData,
  output logic [NUM_REQ-1:0] reqPend,
  output logic               memResetN,
  output logic               memCke,
  output logic               memCsN,
  output logic               memRasN,
  output logic               memCasN,
  output logic               memWeN,
  output logic [ADDR_W-1:0]  memAddr,
  output logic [BANK_W-1:0]  memBank,
  output logic               dramEnabled
);

  localparam logic [ADDR_W-1:0] PREA_ADDR = ADDR_W'(1) << 10;

  logic [ADDR_W-1:0]  mrsAddr;
  logic [BANK_W-1:0]  mrsBank;
  logic               initMode;
  logic               accept;
  logic [NUM_REQ-1:0] reqSet, reqClr;

  assign accept = regWrEn && initMode && memCke;
  assign reqSet = accept ? regWrData[REQ_LSB +: NUM_REQ] : '0;

  always_comb begin
    reqClr = '0;
    if (strobe.clrReq) begin
      unique case (strobe.cmd)
        CMD_PREA: reqClr = 3'b001;
        CMD_REF:  reqClr = 3'b010;
        default:  reqClr = 3'b100;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      mrsAddr     <= '0;
      mrsBank     <= '0;
      initMode    <= 1'b0;
      memResetN   <= 1'b0;
      memCke      <= 1'b0;
      dramEnabled <= 1'b0;
      reqPend     <= '0;
    end else begin
      if (regWrEn) begin
        mrsAddr  <= regWrData[ADDR_W-1:0];
        mrsBank  <= regWrData[ADDR_W +: BANK_W];
        initMode <= regWrData[INIT_BIT];
        if (regWrData[REL_BIT])              memResetN   <= 1'b1;
        if (regWrData[CKE_BIT])              memCke      <= 1'b1;
        if (initMode && !regWrData[INIT_BIT]) dramEnabled <= 1'b1;
      end
      reqPend <= (reqPend & ~reqClr) | reqSet;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      memCsN  <= 1'b1;
      memRasN <= 1'b1;
      memCasN <= 1'b1;
      memWeN  <= 1'b1;
      memAddr <= '0;
      memBank <= '0;
    end else if (strobe.loadCmd) begin
      memCsN <= !strobe.csAssert;
      unique case (strobe.cmd)
        CMD_PREA: begin
          {memRasN, memCasN, memWeN} <= 3'b010;
          memAddr <= PREA_ADDR;
          memBank <= '0;
        end
        CMD_REF: begin
          {memRasN, memCasN, memWeN} <= 3'b001;
          memAddr <= '0;
          memBank <= '0;
        end
        default: begin
          {memRasN, memCasN, memWeN} <= 3'b000;
          memAddr <= mrsAddr;
          memBank <= mrsBank;
        end
      endcase
    end else if (strobe.csAssert) begin
      memCsN <= 1'b0;
    end else begin
      memCsN  <= 1'b1;
      memRasN <= 1'b1;
      memCasN <= 1'b1;
      memWeN  <= 1'b1;
      memAddr <= '0;
      memBank <= '0;
    end
  end

  assign regRdData = {initMode, 2'b00, memCke, memResetN, reqPend, 5'b00000,
                      mrsBank, mrsAddr};

  assert_clear_pending_R3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clrReq |-> ((reqPend & reqClr) != '0));

  assert_reset_oneway_R6: assert property (@(posedge clk) disable iff (!rstN)
    memResetN |=> memResetN);

  assert_cke_oneway_R7: assert property (@(posedge clk) disable iff (!rstN)
    memCke |=> memCke);

  assert_enabled_rise_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dramEnabled) |-> ($past(initMode) && !initMode));

  assert_cs_single_R12: assert property (@(posedge clk) disable iff (!rstN)
    !memCsN |=> memCsN);

  assert_cs_needs_cke_R4: assert property (@(posedge clk) disable iff (!rstN)
    !memCsN |-> memCke);

endmodule

// File: rtl/dram_init_seq.sv
module dram_init_seq
  import dram_init_pkg::*;
#(
  parameter int T_RP  = 3,
  parameter int T_RFC = 8,
  parameter int T_MRD = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWrEn,
  input  logic [31:0] regWrData,
  output logic [31:0] regRdData,
  input  logic        twoTMode,
  output logic        memResetN,
  output logic        memCke,
  output logic        memCsN,
  output logic        memRasN,
  output logic        memCasN,
  output logic        memWeN,
  output logic [15:0] memAddr,
  output logic [2:0]  memBank,
  output logic        dramEnabled
);

  ctl_strobe_t        strobe;
  logic [NUM_REQ-1:0] reqPend;
  logic               cntLast;

  dram_init_ctl u_ctl (
    .clk      (clk),
    .rstN     (rstN),
    .reqPend  (reqPend),
    .twoTMode (twoTMode),
    .cntLast  (cntLast),
    .strobe   (strobe)
  );

  dram_init_timer #(.T_RP(T_RP), .T_RFC(T_RFC), .T_MRD(T_MRD)) u_timer (
    .clk     (clk),
    .rstN    (rstN),
    .loadCnt (strobe.loadCnt),
    .cmd     (strobe.cmd),
    .cntLast (cntLast)
  );

  dram_init_dp u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .regWrEn     (regWrEn),
    .regWrData   (regWrData),
    .strobe      (strobe),
    .regRdData   (regRdData),
    .reqPend     (reqPend),
    .memResetN   (memResetN),
    .memCke      (memCke),
    .memCsN      (memCsN),
    .memRasN     (memRasN),
    .memCasN     (memCasN),
    .memWeN      (memWeN),
    .memAddr     (memAddr),
    .memBank     (memBank),
    .dramEnabled (dramEnabled)
  );

endmodule

// File: tb/dram_init_seq_tb.sv
module dram_init_seq_tb;

  localparam int TRP  = 3;
  localparam int TRFC = 8;
  localparam int TMRD = 2;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rstN, regWrEn, twoTMode;
  logic [31:0] regWrData, regRdData;
  logic        memResetN, memCke, memCsN, memRasN, memCasN, memWeN, dramEnabled;
  logic [15:0] memAddr;
  logic [2:0]  memBank;

  dram_init_seq #(.T_RP(TRP), .T_RFC(TRFC), .T_MRD(TMRD)) u_dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdData(regRdData), .twoTMode(twoTMode), .memResetN(memResetN),
    .memCke(memCke), .memCsN(memCsN), .memRasN(memRasN), .memCasN(memCasN),
    .memWeN(memWeN), .memAddr(memAddr), .memBank(memBank),
    .dramEnabled(dramEnabled)
  );

  int    checks = 0;
  int    fails  = 0;
  bit    running = 0;
  bit    done = 0;
  string phaseTag = "R11";

  // Reference model state
  bit [2:0]  mPend, mClr, mSet;
  bit [15:0] mAddr, cAddr;
  bit [2:0]  mBank, cBank;
  bit        mRel, mCke, mInit, mEn, mBusy, mJustReset;
  int        mAge, mCmd, mCsEdge, mT;
  bit        eCs, eRas, eCas, eWe;
  bit [15:0] eA;
  bit [2:0]  eB;
  bit [2:0]  cStr;

  always @(posedge clk) begin
    if (!rstN) begin
      mPend = 0; mAddr = 0; mBank = 0; mRel = 0; mCke = 0; mInit = 0; mEn = 0;
      mBusy = 0; mAge = 0; eCs = 1; eRas = 1; eCas = 1; eWe = 1; eA = 0; eB = 0;
      mJustReset = 1;
    end else begin
      mJustReset = 0;
      mClr = 0;
      if (mBusy) begin
        mAge++;
        if (mAge == mCsEdge + mT) begin
          mClr[mCmd] = 1'b1;
          mBusy = 0;
        end
      end else if (mPend != 0) begin
        mCmd    = mPend[0] ? 0 : (mPend[1] ? 1 : 2);
        mBusy   = 1;
        mAge    = 0;
        mCsEdge = twoTMode ? 1 : 0;
        case (mCmd)
          0: begin mT = TRP;  cStr = 3'b010; cAddr = 16'h0400; cBank = 0; end
          1: begin mT = TRFC; cStr = 3'b001; cAddr = 16'h0000; cBank = 0; end
          default: begin mT = TMRD; cStr = 3'b000; cAddr = mAddr; cBank = mBank; end
        endcase
      end
      if (mBusy && mAge <= mCsEdge) begin
        eCs = (mAge == mCsEdge) ? 1'b0 : 1'b1;
        {eRas, eCas, eWe} = cStr;
        eA = cAddr; eB = cBank;
      end else begin
        eCs = 1; eRas = 1; eCas = 1; eWe = 1; eA = 0; eB = 0;
      end
      mSet = (regWrEn && mInit && mCke) ? regWrData[26:24] : 3'b000;
      mPend = (mPend & ~mClr) | mSet;
      if (regWrEn) begin
        if (mInit && !regWrData[31]) mEn = 1;
        mAddr = regWrData[15:0];
        mBank = regWrData[18:16];
        mInit = regWrData[31];
        if (regWrData[27]) mRel = 1;
        if (regWrData[28]) mCke = 1;
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s (%s) t=%0t actual=%h expected=%h", req, phaseTag, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (running) begin
      if (mJustReset) begin
        chk("R11 pins", {memResetN, memCke, memCsN, memRasN, memCasN, memWeN, dramEnabled},
            {7'b0011110});
        chk("R11 word", regRdData, 32'h0);
      end else begin
        chk("R12 csN", memCsN, eCs);
        chk("R2 strobes", {memRasN, memCasN, memWeN}, {eRas, eCas, eWe});
        chk("R1 addr/bank pins", {memBank, memAddr}, {eB, eA});
        chk("R1 field readback", regRdData[18:0], {mBank, mAddr});
        chk("R3 request bits", regRdData[26:24], mPend);
        chk("R10 reserved", {regRdData[30:29], regRdData[23:19]}, 7'b0);
        chk("R6 reset pin", {memResetN, regRdData[27]}, {mRel, mRel});
        chk("R7 cke pin", {memCke, regRdData[28]}, {mCke, mCke});
        chk("R8 enabled", {dramEnabled, regRdData[31]}, {mEn, mInit});
      end
    end
  end

  task automatic wr(input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0; regWrData = 32'h0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    rstN = 1'b0; regWrEn = 1'b0; regWrData = 32'h0; twoTMode = 1'b0;
    @(posedge clk);
    running = 1;
    idle(3);
    rstN = 1'b1;
    idle(2);
    phaseTag = "R4";
    wr(32'h8100_0000);
    wr(32'h8100_0000);
    idle(3);
    phaseTag = "R6 R7";
    wr(32'h8800_0000);
    wr(32'h9000_0000);
    wr(32'h8000_0000);
    idle(2);
    phaseTag = "R2 R12";
    wr(32'h9100_0000);
    idle(8);
    wr(32'h9200_0000);
    idle(12);
    wr(32'h9405_1234);
    idle(6);
    phaseTag = "R5";
    wr(32'h9703_ABCD);
    idle(30);
    phaseTag = "R9";
    twoTMode = 1'b1;
    wr(32'h9706_5A5A);
    idle(30);
    wr(32'h9400_0F0F);
    idle(10);
    twoTMode = 1'b0;
    phaseTag = "R10";
    wr(32'hF8F8_0000);
    idle(3);
    phaseTag = "R8";
    wr(32'h1000_0000);
    idle(2);
    wr(32'h1100_0000);
    idle(3);
    wr(32'h9000_0000);
    idle(2);
    phaseTag = "R3";
    wr(32'h9200_0000);
    wr(32'h9000_0000);
    idle(14);
    phaseTag = "R11";
    rstN = 1'b0;
    idle(2);
    rstN = 1'b1;
    idle(3);
    running = 0;
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired t=%0t actual=running expected=finished", $time);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule